// File: doc/BRIEF.md
# Serial Register Target with Strap Address and Pointer Stepping

This block is an I2C target that lets a host read and write an internal file of 8-bit registers. A system clock samples SCL and SDA and finds START and STOP conditions and bit edges. After a START, the first byte carries the 7-bit station address and the read/write bit. The upper four address bits are fixed and the lower three come from strap pins, so one board can carry up to eight of these targets. In a write transfer, the byte after the address is a sub-address. Its low seven bits load the register pointer. Its top bit chooses whether the pointer steps after each data byte or stays where it is. A repeated START followed by a read address then returns registers starting at that pointer.

SDA leaves the block as an open-drain pull-down enable, with a monitor output that shows when the pull-down is active. Bit 3 of the configuration register at sub-address 0x00 steers the incoming SCL level to one of two camera-side SCL outputs and is also driven out as a port-select status. A plain register array stands in for the functions behind the registers. It has a block of constant read-only locations and an unmapped upper range.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address {4'b0110, strap[2:0]}, i.e. write byte 0x60 + 2*strap and read byte 0x61 + 2*strap. Acknowledging means holding SDA low during the ninth clock. For any other address it leaves SDA released for the rest of that transfer.
- R2: In a write transfer, the first byte after the address is the sub-address and its bits 6:0 load the register pointer. Each following byte is stored at the pointer. Every such byte is acknowledged.
- R3: When sub-address bit 7 is 1, the pointer advances by one after each data byte written or read. Stepping from 0x7F wraps the pointer to 0x00.
- R4: When sub-address bit 7 is 0, the pointer does not move, so repeated writes or reads all use the same register.
- R5: In a read transfer, the block sends the register at the pointer MSB first and releases SDA during the ninth clock. On a master ACK it sends the next byte. After a NACK it drives nothing until the next START.
- R6: A repeated START restarts address decoding but keeps the pointer loaded by the earlier sub-address.
- R7: Bit 3 of register 0x00 selects the port: 0 copies SCL to sclPortA and holds sclPortB high, and 1 does the reverse. portSel shows the bit. Bits 7:4 of register 0x00 always read 0.
- R8: Sub-addresses 0x10 to 0x1F are read-only and return (sub-address XOR 0xA5). Sub-addresses 0x40 to 0x7F read 0. Writes to either range are acknowledged and leave the read value unchanged.
- R9: sdaMon is low exactly while sdaDrvLow is high. sdaDrvLow changes only while SCL is low.
- R10: After reset, SDA is released, portSel is 0 and every writable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | I2C clock level from the bus |
| sdaIn | input | 1 | I2C data level from the bus |
| strap | input | 3 | Station address strap bits (address bits 2:0) |
| sdaDrvLow | output | 1 | Open-drain pull-down enable for SDA (1 = pull low) |
| sdaMon | output | 1 | Low while the block pulls SDA low |
| sclPortA | output | 1 | SCL copy for camera port A, high when B is selected |
| sclPortB | output | 1 | SCL copy for camera port B, high when A is selected |
| portSel | output | 1 | Selected camera port (0 = A, 1 = B) |

## Verification
Multi-byte bursts are run twice with the same sub-address low bits, once with the stepping bit set and once clear. The readback then tells a pointer that steps apart from one that stays put, and a wrap from 0x7F onto the configuration register shows up on portSel. Reads of the read-only block, the unmapped range and the masked configuration bits, each after a write, separate a stored value from a constant one. Foreign addresses, and a strap change that moves the station address, show whether the decode uses the strap. An extra byte clocked after a NACK shows whether the block really stops driving.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 7;

  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    K_ADDR, K_SUB, K_DATA
  } byteKind_t;
endpackage

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'h6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strb,
  output logic              sdaDrvLow
);
  logic [1:0] sclSync, sdaSync;
  logic sclP, sdaP;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclSync[1];
      sdaP    <= sdaSync[1];
    end
  end

  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet, addrHit;
  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign addrHit  = (rxByte[7:1] == {ADDR_HI, strap});

  busState_t state;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic rdMode, mAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      kind   <= K_ADDR;
      bitCnt <= '0;
      rdMode <= 1'b0;
      mAck   <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && bitCnt == 4'd8) begin
            bitCnt <= '0;
            if (kind == K_ADDR) rdMode <= rxByte[0];
            state <= (kind == K_ADDR && !addrHit) ? ST_IDLE : ST_ACK;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (kind == K_ADDR && rdMode) state <= ST_TX;
            else begin
              state <= ST_RX;
              kind  <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state  <= ST_TXACK;
              bitCnt <= '0;
            end else bitCnt <= bitCnt + 4'd1;
          end
        end
        ST_TXACK: begin
          if (sclRise) mAck <= ~sdaS;
          else if (sclFall) state <= mAck ? ST_TX : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.rxBit    = sdaS;
    strb.shiftIn  = (state == ST_RX) && sclRise;
    strb.loadPtr  = (state == ST_RX) && sclFall && bitCnt == 4'd8 && kind == K_SUB;
    strb.writeReg = (state == ST_RX) && sclFall && bitCnt == 4'd8 && kind == K_DATA;
    strb.loadTx   = ((state == ST_ACK) && sclFall && kind == K_ADDR && rdMode) ||
                    ((state == ST_TXACK) && sclFall && mAck);
    strb.shiftTx  = (state == ST_TX) && sclFall && bitCnt != 4'd7;
  end

  assign sdaDrvLow = (state == ST_ACK) || (state == ST_TX && !txBit);

  // SDA may only move while the sampled clock is low
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclS); // R9
  // a data byte can only reach the register file after the address was accepted
  AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeReg |-> (kind == K_DATA) && !rdMode); // R2
endmodule

// File: rtl/i2c_reg_dp.sv
module i2c_reg_dp
  import i2c_reg_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int RO_BASE  = 16,
  parameter int RO_COUNT = 16,
  parameter logic [7:0] RO_SEED = 8'hA5,
  parameter int CFG_BITS = 4,
  parameter int SEL_BIT  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit,
  output logic              portSel
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((1 << CFG_BITS) - 1);

  logic [PTR_W-1:0]  ptr;
  logic              autoInc;
  logic [DATA_W-1:0] rxShift, txShift, readVal;
  logic [DATA_W-1:0] regView [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    if (g >= RO_BASE && g < RO_BASE + RO_COUNT) begin : gRo
      assign regView[g] = DATA_W'(g) ^ RO_SEED;
    end else begin : gRw
      localparam logic [DATA_W-1:0] KEEP = (g == 0) ? CFG_MASK : '1;
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strb.writeReg && ptr == PTR_W'(g)) q <= rxShift & KEEP;
      end
      assign regView[g] = q;
    end
  end

  always_comb begin
    if (int'(ptr) < NUM_REGS) readVal = regView[ptr[IDX_W-1:0]];
    else readVal = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      autoInc <= 1'b0;
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], strb.rxBit};
      if (strb.loadPtr) begin
        ptr     <= rxShift[PTR_W-1:0];
        autoInc <= rxShift[DATA_W-1];
      end else if ((strb.writeReg || strb.loadTx) && autoInc) begin
        ptr <= ptr + PTR_W'(1);
      end
      if (strb.loadTx) txShift <= readVal;
      else if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end

  assign rxByte  = rxShift;
  assign txBit   = txShift[DATA_W-1];
  assign portSel = regView[0][SEL_BIT];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.writeReg || strb.loadTx) && autoInc) |=> (ptr == $past(ptr) + PTR_W'(1))); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.writeReg || strb.loadTx) && !autoInc) |=> $stable(ptr)); // R4
  AST_SEL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portSel) |-> ($past(strb.writeReg) && $past(ptr) == '0)); // R7
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'h6,
  parameter int NUM_REGS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  output logic       sdaDrvLow,
  output logic       sdaMon,
  output logic       sclPortA,
  output logic       sclPortB,
  output logic       portSel
);
  dpStrobe_t strb;
  logic [DATA_W-1:0] rxByte;
  logic txBit;

  i2c_reg_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaDrvLow(sdaDrvLow)
  );

  i2c_reg_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxByte(rxByte), .txBit(txBit), .portSel(portSel)
  );

  assign sdaMon   = ~sdaDrvLow;
  assign sclPortA = portSel ? 1'b1 : sclIn;
  assign sclPortB = portSel ? sclIn : 1'b1;
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaDrvLow, sdaMon, sclPortA, sclPortB, portSel;
  logic sdaBus;
  assign sdaBus = mSda & ~sdaDrvLow;

  i2c_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strap(strap),
    .sdaDrvLow(sdaDrvLow), .sdaMon(sdaMon), .sclPortA(sclPortA),
    .sclPortB(sclPortB), .portSel(portSel)
  );

  localparam int Q = 10;
  int nChecks = 0, nFail = 0;
  logic [7:0] wAddr = 8'h6A;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [7:0] actQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic waitQ;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic expectRead(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic [7:0] a, e;
      string t;
      wait (actQ.size() != 0);
      a = actQ.pop_front();
      if (expQ.size() == 0) check(1'b0, "unexpected read byte", a, 0);
      else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  task automatic busStart;
    mSda = 1; mScl = 1; waitQ; mSda = 0; waitQ; mScl = 0; waitQ;
  endtask
  task automatic busRestart;
    mSda = 1; waitQ; mScl = 1; waitQ; mSda = 0; waitQ; mScl = 0; waitQ;
  endtask
  task automatic busStop;
    mSda = 0; waitQ; mScl = 1; waitQ; mSda = 1; waitQ; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked, output logic mon);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ; mScl = 1; waitQ; waitQ; mScl = 0; waitQ;
    end
    mSda = 1; waitQ; mScl = 1; waitQ;
    acked = !sdaBus;
    mon = sdaMon;
    waitQ; mScl = 0; waitQ;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSda = 1;
    for (int i = 7; i >= 0; i--) begin
      waitQ; mScl = 1; waitQ; b[i] = sdaBus; waitQ; mScl = 0;
    end
    waitQ; mSda = giveAck ? 1'b0 : 1'b1; waitQ; mScl = 1; waitQ; waitQ; mScl = 0;
    waitQ; mSda = 1; waitQ;
  endtask

  task automatic wrBurst(input logic [7:0] sub, input logic [31:0] data, input int n,
                         input string tag);
    bit ack;
    logic mon;
    busStart;
    sendByte(wAddr, ack, mon);
    check(ack, "R1 write address ACK", ack, 1);
    check(mon == 1'b0, "R9 sdaMon low during ACK", mon, 0);
    sendByte(sub, ack, mon);
    check(ack, "R2 sub-address ACK", ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(data[8*i +: 8], ack, mon);
      check(ack, tag, ack, 1);
    end
    busStop;
  endtask

  task automatic rdBurst(input logic [7:0] sub, input int n, input bit extraAfterNack);
    bit ack;
    logic mon;
    logic [7:0] b;
    busStart;
    sendByte(wAddr, ack, mon);
    sendByte(sub, ack, mon);
    busRestart;
    sendByte(wAddr | 8'h01, ack, mon);
    check(ack, "R6 read address ACK after repeated START", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      actQ.push_back(b);
    end
    if (extraAfterNack) begin
      recvByte(1'b0, b);
      check(b == 8'hFF, "R5 bus idle after NACK", b, 8'hFF);
    end
    busStop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary;
  end

  initial begin
    bit ack;
    logic mon;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    waitQ;
    // R10 reset state
    check(sdaDrvLow == 1'b0, "R10 SDA released after reset", sdaDrvLow, 0);
    check(sdaMon == 1'b1, "R9 sdaMon high when released", sdaMon, 1);
    check(portSel == 1'b0, "R10 portSel after reset", portSel, 0);
    mScl = 0; #3;
    check(sclPortA == 1'b0, "R7 port A follows SCL low", sclPortA, 0);
    check(sclPortB == 1'b1, "R7 port B held high", sclPortB, 1);
    mScl = 1; waitQ;
    expectRead(8'h00, "R10 writable register zero after reset");
    rdBurst(8'h05, 1, 1'b0);

    // R3 stepping burst, R6 pointer kept across repeated START
    wrBurst(8'h85, 32'h00332211, 3, "R2 data byte ACK");
    expectRead(8'h11, "R3 burst byte 0");
    expectRead(8'h22, "R3 burst byte 1");
    expectRead(8'h33, "R3 burst byte 2");
    rdBurst(8'h85, 3, 1'b0);
    // R5 NACK then extra clocks
    expectRead(8'h11, "R5 single read before NACK");
    rdBurst(8'h05, 1, 1'b1);

    // R4 fixed pointer
    wrBurst(8'h07, 32'h0000BBAA, 2, "R4 data byte ACK");
    expectRead(8'hBB, "R4 fixed pointer read 0");
    expectRead(8'hBB, "R4 fixed pointer read 1");
    rdBurst(8'h07, 2, 1'b0);
    expectRead(8'h00, "R4 neighbour untouched");
    rdBurst(8'h08, 1, 1'b0);

    // R1 foreign address
    busStart;
    sendByte(8'h68, ack, mon);
    check(!ack, "R1 foreign address not ACKed", ack, 0);
    sendByte(8'h00, ack, mon);
    check(!ack, "R1 no ACK for rest of transfer", ack, 0);
    busStop;

    // R3 wrap 0x7F -> 0x00, R7 port select
    wrBurst(8'hFF, 32'h00003C5A, 2, "R8 unmapped write ACK");
    check(portSel == 1'b1, "R7 portSel set by wrap write", portSel, 1);
    mScl = 0; #3;
    check(sclPortA == 1'b1, "R7 port A held high", sclPortA, 1);
    check(sclPortB == 1'b0, "R7 port B follows SCL low", sclPortB, 0);
    mScl = 1; waitQ;
    expectRead(8'h0C, "R7 upper config bits read zero");
    rdBurst(8'h00, 1, 1'b0);
    expectRead(8'h00, "R8 unmapped reads zero");
    rdBurst(8'h7F, 1, 1'b0);

    // R8 read-only block
    wrBurst(8'h12, 32'h00000000, 1, "R8 read-only write ACK");
    expectRead(8'hB7, "R8 read-only 0x12");
    expectRead(8'hB6, "R8 read-only 0x13");
    rdBurst(8'h92, 2, 1'b0);
    wrBurst(8'h40, 32'h00000077, 1, "R8 unmapped write ACK");
    expectRead(8'h00, "R8 unmapped write ignored");
    rdBurst(8'h40, 1, 1'b0);

    // back to port A
    wrBurst(8'h00, 32'h000000F0, 1, "R7 config write ACK");
    check(portSel == 1'b0, "R7 portSel cleared", portSel, 0);
    expectRead(8'h00, "R7 config reads zero");
    rdBurst(8'h00, 1, 1'b0);

    // R1 strap change
    strap = 3'b000;
    wAddr = 8'h60;
    waitQ;
    wrBurst(8'h09, 32'h00000099, 1, "R1 data ACK at new strap");
    expectRead(8'h99, "R1 readback at new strap");
    rdBurst(8'h09, 1, 1'b0);
    busStart;
    sendByte(8'h6A, ack, mon);
    check(!ack, "R1 old address ignored after strap change", ack, 0);
    busStop;

    waitQ;
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    summary;
  end
endmodule